// File: doc/BRIEF.md
# Folded Symmetric FIR Tap Datapath

This block computes a symmetric finite impulse response filter with half the number of multipliers a direct form would need. A forward delay line carries incoming samples toward the far end of the filter. A reverse delay line carries them back. Each pre-adder sums one sample from each line, so every coefficient is shared by the two taps that mirror each other. The pre-added pairs are multiplied by their coefficients, and a registered adder tree reduces the products to one full-precision sum.

Two configuration inputs choose the point where the forward line turns into the reverse line. Even-length filters use the output of the last forward element. Odd-length filters turn one sample earlier, which puts the centre sample on both inputs of the last pre-adder. Odd-length filters on interleaved data turn at the next-to-last forward element. When the centre sample is counted twice, the centre coefficient has to be supplied at half its intended value. Every delay element holds `IL` samples, so several interleaved streams can share the filter. All delay elements advance only on a valid input sample.

Top module: `folded_sym_fir`

## Requirements
- R1: A synchronous reset clears every delay element and pipeline register. In the cycle after reset, outValid is 0 and outSum is 0, and samples accepted before the reset add nothing to later sums.
- R2: Let m be the latest accepted sample, L = IL, N = TAPS, x[j] = 0 for samples before reset, and c_k the signed value in coefs bits [12k+11:12k]. For sample m the output is the sum over k = 0..N-1 of c_k·(x[m−k·L] + x[m−D−(N−1−k)·L]). The turn offset D is set by the mode.
- R3: With cfgOddIl = 0 and cfgOddTaps = 0 (even folding), D = N·L: the last forward element feeds the reverse line.
- R4: With cfgOddIl = 0 and cfgOddTaps = 1 (odd folding), D = N·L−1: the reverse line is fed from one sample before the last forward element's output. When L = 1, the centre sample reaches both inputs of the last pre-adder.
- R5: With cfgOddIl = 1 (odd interleaved folding), D = (N−1)·L whatever the value of cfgOddTaps. The next-to-last forward element feeds the reverse line, and the centre sample reaches both inputs of the last pre-adder.
- R6: The delay lines shift only in cycles where inValid is 1. Idle cycles between samples leave the result unchanged.
- R7: outValid is high exactly $clog2(N)+2 cycles after the clock edge that accepts a sample, for one cycle per accepted sample, and never without an accepted input.
- R8: The sum keeps full precision. All samples and coefficients at −2048 give 2·2048·2048 per pair with no wrap.
- R9: While no sample is accepted and the coefficients are unchanged, outSum holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Accept inSample this cycle |
| inSample | input | 12 | Signed input sample |
| coefs | input | TAPS*12 | Signed coefficient set, coefficient k in bits [12k+11:12k] |
| cfgOddTaps | input | 1 | Select odd folding |
| cfgOddIl | input | 1 | Select odd interleaved folding (overrides cfgOddTaps) |
| outValid | output | 1 | outSum holds the result of an accepted sample |
| outSum | output | 32 | Signed full-precision filter sum |

## Verification
The bench builds the filter with TAPS = 8 and IL = 2. With an interleave depth of two, the three turn points give three different reverse-line offsets, 16, 15 and 14 samples, so a wrong mode decode changes the sums. Eight pairs give a three-level adder tree, which puts the valid latency at five cycles. An impulse run exposes both the coefficient slot order and the reverse-line offset directly.

// File: rtl/fsf_pkg.sv
package fsf_pkg;

  typedef enum logic [1:0] {
    FEED_EVEN   = 2'd0,
    FEED_ODD    = 2'd1,
    FEED_ODD_IL = 2'd2
  } feedSel_e;

  typedef struct packed {
    logic     shiftEn;
    feedSel_e feedSel;
  } dpCtl_t;

endpackage

// File: rtl/fsf_ctrl.sv
module fsf_ctrl
  import fsf_pkg::*;
#(
  parameter int PIPE_LEN = 6
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   inValid,
  input  logic   cfgOddTaps,
  input  logic   cfgOddIl,
  output dpCtl_t ctl,
  output logic   outValid
);

  logic [PIPE_LEN-1:0] vPipe;

  always_comb begin
    ctl.shiftEn = inValid;
    if (cfgOddIl)        ctl.feedSel = FEED_ODD_IL;
    else if (cfgOddTaps) ctl.feedSel = FEED_ODD;
    else                 ctl.feedSel = FEED_EVEN;
  end

  always_ff @(posedge clk) begin
    if (rst) vPipe <= '0;
    else     vPipe <= {vPipe[PIPE_LEN-2:0], inValid};
  end

  assign outValid = vPipe[PIPE_LEN-1];

endmodule

// File: rtl/fsf_datapath.sv
module fsf_datapath
  import fsf_pkg::*;
#(
  parameter int TAPS = 8,
  parameter int IL   = 2,
  parameter int SW   = 12,
  parameter int CW   = 12,
  parameter int OW   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dpCtl_t               ctl,
  input  logic signed [SW-1:0] inSample,
  input  logic [TAPS*CW-1:0]   coefs,
  output logic signed [OW-1:0] outSum
);

  localparam int FWD_LEN = (TAPS - 1) * IL + 1;
  localparam int REV_LEN = TAPS * IL;
  localparam int LEVELS  = $clog2(TAPS);
  localparam int LEAVES  = 1 << LEVELS;
  localparam int PRE_W   = SW + 1;
  localparam int PROD_W  = PRE_W + CW;

  logic signed [SW-1:0]     fwdLine [FWD_LEN];
  logic signed [SW-1:0]     revLine [REV_LEN];
  logic signed [SW-1:0]     revIn;
  logic signed [PRE_W-1:0]  preSum  [TAPS];
  logic signed [PROD_W-1:0] prod    [TAPS];
  logic signed [OW-1:0]     sumNode [1:LEAVES-1];
  logic signed [OW-1:0]     allNode [1:2*LEAVES-1];

  // turn point from the forward line into the reverse line
  always_comb begin
    case (ctl.feedSel)
      FEED_ODD:    revIn = fwdLine[(TAPS-1)*IL-1];
      FEED_ODD_IL: revIn = fwdLine[(TAPS-2)*IL];
      default:     revIn = fwdLine[(TAPS-1)*IL];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < FWD_LEN; j++) fwdLine[j] <= '0;
      for (int j = 0; j < REV_LEN; j++) revLine[j] <= '0;
    end else if (ctl.shiftEn) begin
      fwdLine[0] <= inSample;
      for (int j = 1; j < FWD_LEN; j++) fwdLine[j] <= fwdLine[j-1];
      revLine[0] <= revIn;
      for (int j = 1; j < REV_LEN; j++) revLine[j] <= revLine[j-1];
    end
  end

  // leaves of the tree are the products, padded with zeros
  always_comb begin
    for (int i = 1; i < LEAVES; i++) allNode[i] = sumNode[i];
    for (int i = 0; i < LEAVES; i++) begin
      if (i < TAPS) allNode[LEAVES+i] = OW'(prod[i]);
      else          allNode[LEAVES+i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) begin
        preSum[k] <= '0;
        prod[k]   <= '0;
      end
      for (int i = 1; i < LEAVES; i++) sumNode[i] <= '0;
    end else begin
      for (int k = 0; k < TAPS; k++) begin
        preSum[k] <= PRE_W'(fwdLine[k*IL]) + PRE_W'(revLine[(TAPS-k)*IL-1]);
        prod[k]   <= preSum[k] * $signed(coefs[k*CW +: CW]);
      end
      for (int i = 1; i < LEAVES; i++) sumNode[i] <= allNode[2*i] + allNode[2*i+1];
    end
  end

  assign outSum = sumNode[1];

endmodule

// File: rtl/folded_sym_fir.sv
module folded_sym_fir
  import fsf_pkg::*;
#(
  parameter int TAPS = 8,
  parameter int IL   = 2,
  parameter int SW   = 12,
  parameter int CW   = 12,
  parameter int OW   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic signed [SW-1:0] inSample,
  input  logic [TAPS*CW-1:0]   coefs,
  input  logic                 cfgOddTaps,
  input  logic                 cfgOddIl,
  output logic                 outValid,
  output logic signed [OW-1:0] outSum
);

  localparam int PIPE_LEN = $clog2(TAPS) + 3;

  dpCtl_t ctl;

  fsf_ctrl #(.PIPE_LEN(PIPE_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .cfgOddTaps(cfgOddTaps), .cfgOddIl(cfgOddIl),
    .ctl(ctl), .outValid(outValid)
  );

  fsf_datapath #(.TAPS(TAPS), .IL(IL), .SW(SW), .CW(CW), .OW(OW)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .inSample(inSample),
    .coefs(coefs), .outSum(outSum)
  );

endmodule

// File: rtl/folded_sym_fir_chk.sv
module folded_sym_fir_chk #(
  parameter int TAPS = 8,
  parameter int CW   = 12,
  parameter int OW   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic [TAPS*CW-1:0] coefs,
  input logic               outValid,
  input logic [OW-1:0]      outSum
);

  localparam int PIPE = $clog2(TAPS) + 3;

  logic [PIPE-1:0]    vShadow;
  logic               rstQ;
  logic [TAPS*CW-1:0] coefsQ;
  int unsigned        idleCnt;
  int unsigned        acceptCnt;

  always_ff @(posedge clk) begin
    rstQ   <= rst;
    coefsQ <= coefs;
    if (rst) begin
      vShadow   <= '0;
      idleCnt   <= 0;
      acceptCnt <= 0;
    end else begin
      vShadow <= {vShadow[PIPE-2:0], inValid};
      if (inValid || coefs != coefsQ) idleCnt <= 0;
      else if (idleCnt < 1000)        idleCnt <= idleCnt + 1;
      if (inValid && acceptCnt < 1000) acceptCnt <= acceptCnt + 1;
    end
  end

  // R1: state cleared one cycle after reset
  always @(posedge clk) begin
    if (rstQ == 1'b1)
      a_r1_reset_clears: assert (!outValid && outSum == '0);
  end

  a_r7_valid_latency: assert property (@(posedge clk) disable iff (rst)
    outValid == vShadow[PIPE-1]);

  a_r7_no_valid_without_input: assert property (@(posedge clk) disable iff (rst)
    (acceptCnt == 0) |-> !outValid);

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (idleCnt > PIPE) |=> $stable(outSum));

endmodule

bind folded_sym_fir folded_sym_fir_chk #(.TAPS(TAPS), .CW(CW), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .coefs(coefs),
  .outValid(outValid), .outSum(outSum)
);

// File: tb/folded_sym_fir_bench.sv
module folded_sym_fir_bench;

  localparam int N   = 8;
  localparam int L   = 2;
  localparam int LAT = $clog2(N) + 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic signed [11:0] inSample = '0;
  logic [N*12-1:0]   coefs = '0;
  logic              cfgOddTaps = 1'b0;
  logic              cfgOddIl = 1'b0;
  logic              outValid;
  logic signed [31:0] outSum;

  folded_sym_fir #(.TAPS(N), .IL(L)) u_folded_sym_fir (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .coefs(coefs), .cfgOddTaps(cfgOddTaps), .cfgOddIl(cfgOddIl),
    .outValid(outValid), .outSum(outSum)
  );

  always #2 clk = ~clk;

  int     nChecks = 0;
  int     nFails = 0;
  int     cyc = 0;
  int     turnD = N * L;
  int     cf[N];
  int     hist[$];
  int     expQ[$];
  int     accQ[$];
  int     lastExp = 0;
  string  curTag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: each output is compared with the model, and its latency too (R7)
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expQ.size() == 0) check("R7 unexpected outValid", 1, 0);
      else begin
        check(curTag, outSum, expQ.pop_front());
        check("R7 latency", cyc - accQ.pop_front(), LAT);
      end
    end
  end

  function automatic int xAt(int j);
    return (j < 0) ? 0 : hist[j];
  endfunction

  function automatic int model();
    int m = hist.size() - 1;
    int acc = 0;
    for (int k = 0; k < N; k++)
      acc += cf[k] * (xAt(m - k*L) + xAt(m - turnD - (N-1-k)*L));
    return acc;
  endfunction

  task automatic setCoefs();
    for (int k = 0; k < N; k++) coefs[k*12 +: 12] = 12'(cf[k]);
  endtask

  task automatic startMode(logic odd, logic oddIl, int d);
    @(negedge clk);
    cfgOddTaps = odd; cfgOddIl = oddIl; turnD = d;
    inValid = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    hist.delete();
  endtask

  task automatic pushSample(int s);
    @(negedge clk);
    inValid = 1'b1; inSample = 12'(s);
    hist.push_back(s);
    lastExp = model();
    expQ.push_back(lastExp);
    accQ.push_back(cyc + 1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  function automatic int nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr[11:0]));
  endfunction

  task automatic drainCheck(string tag);
    idle(LAT + 4);
    check({tag, " outputs drained"}, expQ.size(), 0);
  endtask

  task automatic testReset();
    curTag = "R1";
    for (int k = 0; k < N; k++) cf[k] = k * 37 - 100;
    setCoefs();
    startMode(1'b0, 1'b0, N*L);
    @(negedge clk);
    check("R1 outValid after reset", outValid, 0);
    check("R1 outSum after reset", outSum, 0);
  endtask

  task automatic testEvenImpulse();
    curTag = "R2 R3 impulse";
    startMode(1'b0, 1'b0, N*L);
    pushSample(100);
    for (int i = 0; i < 3*N*L; i++) pushSample(0);
    drainCheck("R3");
  endtask

  task automatic testEvenGaps();
    curTag = "R3 R6 random with gaps";
    startMode(1'b0, 1'b0, N*L);
    for (int i = 0; i < 60; i++) begin
      pushSample(nextRand());
      if (i % 3 == 1) idle(i % 4 + 1);
    end
    drainCheck("R6");
  endtask

  task automatic testOdd();
    curTag = "R4 odd";
    startMode(1'b1, 1'b0, N*L - 1);
    pushSample(50);
    for (int i = 0; i < 2*N*L; i++) pushSample(0);
    for (int i = 0; i < 40; i++) pushSample(nextRand());
    drainCheck("R4");
  endtask

  task automatic testOddIl(logic odd);
    curTag = odd ? "R5 odd-il taps=1" : "R5 odd-il taps=0";
    startMode(odd, 1'b1, (N-1)*L);
    pushSample(-70);
    for (int i = 0; i < 2*N*L; i++) pushSample(0);
    for (int i = 0; i < 40; i++) pushSample(i * 53 - 1000);
    drainCheck("R5");
  endtask

  task automatic testExtreme();
    curTag = "R8 extreme";
    for (int k = 0; k < N; k++) cf[k] = -2048;
    setCoefs();
    startMode(1'b0, 1'b0, N*L);
    for (int i = 0; i < 3*N*L; i++) pushSample(-2048);
    drainCheck("R8");
    check("R8 full scale sum", outSum, N * 2 * 2048 * 2048);
    for (int k = 0; k < N; k++) cf[k] = 2047 - k * 300;
    setCoefs();
  endtask

  task automatic testHold();
    curTag = "R9 stream";
    startMode(1'b0, 1'b0, N*L);
    for (int i = 0; i < 20; i++) pushSample(nextRand());
    idle(LAT + 10);
    check("R9 hold value", outSum, lastExp);
    check("R9 outValid idle", outValid, 0);
    idle(20);
    check("R9 hold later", outSum, lastExp);
  endtask

  task automatic testMidReset();
    curTag = "R1 pre-reset";
    startMode(1'b1, 1'b0, N*L - 1);
    for (int i = 0; i < 30; i++) pushSample(nextRand());
    drainCheck("R1 pre-reset");
    curTag = "R1 post-reset";
    startMode(1'b1, 1'b0, N*L - 1);
    @(negedge clk);
    check("R1 outSum cleared", outSum, 0);
    for (int i = 0; i < 10; i++) pushSample(300 + i);
    drainCheck("R1 post-reset");
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual hung expected finished");
    finishRun();
  end

  initial begin
    testReset();
    testEvenImpulse();
    testEvenGaps();
    testOdd();
    testOddIl(1'b0);
    testOddIl(1'b1);
    testExtreme();
    testHold();
    testMidReset();
    finishRun();
  end

endmodule